// File: doc/BRIEF.md
# Two-Level Address Translation Unit

This block turns a 32-bit virtual address into a 32-bit physical address for a memory system with 4 KB pages and a two-level page table. The virtual page number is split into a directory index (upper 10 bits) and a table index (next 10 bits). The low 12 bits are the byte offset within the page and are passed through unchanged. A small direct-mapped translation buffer answers repeated requests to the same page without touching memory. A two-entry cache of directory entries lets a translation miss skip the first table level when the directory entry is already on hand.

A processor-side client offers one translation at a time with a valid/ready handshake. A hit is answered in the cycle after acceptance. A miss starts a hardware walk that reads table entries over a simple one-read-at-a-time memory port. A walk ends either in a filled translation-buffer entry and a physical address, or in a fault when an entry's present bit is clear.

Three free-running counters report hits, misses and walker memory reads. Software-level access-cost analysis can be checked against them directly.

Top module: `xlate_unit`

## Requirements
- R1: On a successful translation, `rsp_paddr[31:12]` equals bits 31:12 of the fetched table entry (or of the cached translation), and `rsp_paddr[11:0]` equals `req_vaddr[11:0]`. This low field is also carried on faulting responses.
- R2: The directory entry is read at `pd_base + 4*req_vaddr[31:22]`. The table entry is read at `{dir_entry[31:12], req_vaddr[21:12], 2'b00}`. `mem_req_valid` is a one-cycle pulse with its address, and the reply is a one-cycle `mem_rsp_valid` pulse with data, arriving at least one cycle later.
- R3: The translation buffer is direct-mapped. The low log2(TLB_ENTRIES) bits of the virtual page number pick the entry, and the remaining page-number bits are its tag. A completed walk overwrites whatever that entry held.
- R4: A request that hits in the translation buffer gets `rsp_valid` with `rsp_fault`=0 in the cycle after acceptance, and no memory read is issued.
- R5: A miss whose directory entry is not cached makes exactly two memory reads, directory entry first, then table entry.
- R6: The directory-entry cache holds PDC_ENTRIES entries (default 2). It is indexed by the low bits of the directory index and tagged with the full 10-bit directory index. A miss whose directory entry is cached makes exactly one memory read.
- R7: If bit 0 (present) of a fetched directory or table entry is 0, the response has `rsp_fault`=1. Nothing is written into the translation buffer or the directory-entry cache.
- R8: Reset and `flush` clear every valid bit of both caches. The next request then walks both levels.
- R9: Only one request is in flight. `req_ready` is low from the acceptance of a miss until the cycle its response is presented, and at most one memory read is outstanding.
- R10: `hit_count` increments for each accepted request that hits, and `miss_count` for each one that misses. `read_count` increments for each walker memory read. All three clear on reset.
- R11: Under a word-by-word sequential stream each page costs one miss. Its remaining 1023 words hit, so an 8 MB stream from address 0 produces 2048 misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidates all cached translations and directory entries |
| pd_base | input | 32 | Physical base address of the page directory |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle pulse: response present |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_fault | output | 1 | Translation failed (entry not present) |
| mem_req_valid | output | 1 | One-cycle pulse: walker read request |
| mem_req_addr | output | 32 | Walker read address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned table entry |
| hit_count | output | CNT_W | Accepted requests that hit |
| miss_count | output | CNT_W | Accepted requests that missed |
| read_count | output | CNT_W | Memory reads issued by the walker |

## Verification
The hardest state to reach from the ports is the directory-entry cache holding one directory index while a request arrives for a different index of the same low bit. A faulting entry in that state must leave the cache untouched. The stimulus table walks through directory indices 0, 1, 2, 0 and 7 to force such evictions. It then requests a page whose directory entry is absent twice, and a page under the still-cached index 7. The read counts and the fault flag therefore show whether a not-present entry was wrongly cached. Long sequential streams, one dense over eight pages and one sparse over 8 MB, confirm the one-miss-per-page cost and the total read count.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int ADDR_W      = 32;
  localparam int OFF_W       = 12;
  localparam int IDX_W       = 10;
  localparam int VPN_W       = ADDR_W - OFF_W;
  localparam int PFN_W       = ADDR_W - OFF_W;
  localparam int PRESENT_BIT = 0;

  typedef enum logic [1:0] {
    WK_IDLE,
    WK_DIR,
    WK_TBL
  } walk_state_t;
endpackage

// File: rtl/xlate_dm_store.sv
module xlate_dm_store #(
  parameter int ENTRIES = 2,
  parameter int KEY_W   = 20,
  parameter int DATA_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [KEY_W-1:0]  lk_key,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              wr_en,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int IW    = $clog2(ENTRIES);
  localparam int TAG_W = KEY_W - IW;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_mem  [ENTRIES];
  logic [DATA_W-1:0]  data_mem [ENTRIES];

  logic [IW-1:0] lk_idx, wr_idx;
  assign lk_idx = lk_key[IW-1:0];
  assign wr_idx = wr_key[IW-1:0];

  // valid bits: reset and flush win over a fill in the same cycle
  always_ff @(posedge clk) begin
    if (rst || flush) valid_q <= '0;
    else if (wr_en)   valid_q[wr_idx] <= 1'b1;
  end

  // tag and payload storage without reset (RAM-friendly)
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_key[KEY_W-1:IW];
      data_mem[wr_idx] <= wr_data;
    end
  end

  assign lk_hit  = valid_q[lk_idx] && (tag_mem[lk_idx] == lk_key[KEY_W-1:IW]);
  assign lk_data = data_mem[lk_idx];

  // R3
  fill_then_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush) |=> ((lk_key != $past(wr_key)) || (lk_hit && lk_data == $past(wr_data))));

  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !lk_hit);
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xlate_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] pd_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  input  logic              tlb_hit,
  input  logic [PFN_W-1:0]  tlb_pfn,
  input  logic              pdc_hit,
  input  logic [PFN_W-1:0]  pdc_frame,
  output logic              tlb_fill_en,
  output logic [VPN_W-1:0]  tlb_fill_vpn,
  output logic [PFN_W-1:0]  tlb_fill_pfn,
  output logic              pdc_fill_en,
  output logic [IDX_W-1:0]  pdc_fill_dir,
  output logic [PFN_W-1:0]  pdc_fill_frame,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  read_count
);
  walk_state_t       state_q;
  logic [ADDR_W-1:0] va_q;
  logic              accept, entry_ok;

  logic [IDX_W-1:0] req_dir, req_tbl, va_tbl;
  assign req_dir  = req_vaddr[ADDR_W-1 -: IDX_W];
  assign req_tbl  = req_vaddr[OFF_W +: IDX_W];
  assign va_tbl   = va_q[OFF_W +: IDX_W];
  assign accept   = req_valid && req_ready;
  assign entry_ok = mem_rsp_data[PRESENT_BIT];

  logic unused_entry_bits;
  assign unused_entry_bits = ^mem_rsp_data[OFF_W-1:PRESENT_BIT+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= WK_IDLE;
      va_q          <= '0;
      req_ready     <= 1'b1;
      rsp_valid     <= 1'b0;
      rsp_fault     <= 1'b0;
      rsp_paddr     <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      hit_count     <= '0;
      miss_count    <= '0;
      read_count    <= '0;
    end else begin
      rsp_valid     <= 1'b0;
      mem_req_valid <= 1'b0;
      unique case (state_q)
        WK_IDLE: begin
          if (accept) begin
            va_q <= req_vaddr;
            if (tlb_hit) begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b0;
              rsp_paddr <= {tlb_pfn, req_vaddr[OFF_W-1:0]};
              hit_count <= hit_count + CNT_W'(1);
            end else begin
              miss_count    <= miss_count + CNT_W'(1);
              read_count    <= read_count + CNT_W'(1);
              req_ready     <= 1'b0;
              mem_req_valid <= 1'b1;
              if (pdc_hit) begin
                mem_req_addr <= {pdc_frame, req_tbl, 2'b00};
                state_q      <= WK_TBL;
              end else begin
                mem_req_addr <= pd_base + {{(ADDR_W-IDX_W-2){1'b0}}, req_dir, 2'b00};
                state_q      <= WK_DIR;
              end
            end
          end
        end
        WK_DIR: begin
          if (mem_rsp_valid) begin
            if (entry_ok) begin
              mem_req_valid <= 1'b1;
              mem_req_addr  <= {mem_rsp_data[ADDR_W-1:OFF_W], va_tbl, 2'b00};
              read_count    <= read_count + CNT_W'(1);
              state_q       <= WK_TBL;
            end else begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b1;
              rsp_paddr <= {{PFN_W{1'b0}}, va_q[OFF_W-1:0]};
              req_ready <= 1'b1;
              state_q   <= WK_IDLE;
            end
          end
        end
        WK_TBL: begin
          if (mem_rsp_valid) begin
            rsp_valid <= 1'b1;
            rsp_fault <= !entry_ok;
            rsp_paddr <= entry_ok ? {mem_rsp_data[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]}
                                  : {{PFN_W{1'b0}}, va_q[OFF_W-1:0]};
            req_ready <= 1'b1;
            state_q   <= WK_IDLE;
          end
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  // fills happen only on a present entry
  assign tlb_fill_en    = (state_q == WK_TBL) && mem_rsp_valid && entry_ok;
  assign tlb_fill_vpn   = va_q[ADDR_W-1:OFF_W];
  assign tlb_fill_pfn   = mem_rsp_data[ADDR_W-1:OFF_W];
  assign pdc_fill_en    = (state_q == WK_DIR) && mem_rsp_valid && entry_ok;
  assign pdc_fill_dir   = va_q[ADDR_W-1 -: IDX_W];
  assign pdc_fill_frame = mem_rsp_data[ADDR_W-1:OFF_W];

  // R4
  hit_no_walk_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && tlb_hit) |=> (rsp_valid && !rsp_fault && !mem_req_valid));

  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  // R9
  single_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));

  // R7
  fault_no_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> !$past(tlb_fill_en));

  // R5
  fill_ok_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    tlb_fill_en |=> (rsp_valid && !rsp_fault));
endmodule

// File: rtl/xlate_unit.sv
module xlate_unit
  import xlate_pkg::*;
#(
  parameter int TLB_ENTRIES = 2,
  parameter int PDC_ENTRIES = 2,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [ADDR_W-1:0] pd_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  read_count
);
  logic             tlb_hit, pdc_hit, tlb_fill_en, pdc_fill_en;
  logic [PFN_W-1:0] tlb_pfn, pdc_frame, tlb_fill_pfn, pdc_fill_frame;
  logic [VPN_W-1:0] tlb_fill_vpn;
  logic [IDX_W-1:0] pdc_fill_dir;

  xlate_dm_store #(.ENTRIES(TLB_ENTRIES), .KEY_W(VPN_W), .DATA_W(PFN_W)) u_tlb (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .lk_key  (req_vaddr[ADDR_W-1:OFF_W]),
    .lk_hit  (tlb_hit),
    .lk_data (tlb_pfn),
    .wr_en   (tlb_fill_en),
    .wr_key  (tlb_fill_vpn),
    .wr_data (tlb_fill_pfn)
  );

  xlate_dm_store #(.ENTRIES(PDC_ENTRIES), .KEY_W(IDX_W), .DATA_W(PFN_W)) u_pdc (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .lk_key  (req_vaddr[ADDR_W-1 -: IDX_W]),
    .lk_hit  (pdc_hit),
    .lk_data (pdc_frame),
    .wr_en   (pdc_fill_en),
    .wr_key  (pdc_fill_dir),
    .wr_data (pdc_fill_frame)
  );

  xlate_walker #(.CNT_W(CNT_W)) u_walk (
    .clk            (clk),
    .rst            (rst),
    .pd_base        (pd_base),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_vaddr      (req_vaddr),
    .rsp_valid      (rsp_valid),
    .rsp_paddr      (rsp_paddr),
    .rsp_fault      (rsp_fault),
    .tlb_hit        (tlb_hit),
    .tlb_pfn        (tlb_pfn),
    .pdc_hit        (pdc_hit),
    .pdc_frame      (pdc_frame),
    .tlb_fill_en    (tlb_fill_en),
    .tlb_fill_vpn   (tlb_fill_vpn),
    .tlb_fill_pfn   (tlb_fill_pfn),
    .pdc_fill_en    (pdc_fill_en),
    .pdc_fill_dir   (pdc_fill_dir),
    .pdc_fill_frame (pdc_fill_frame),
    .mem_req_valid  (mem_req_valid),
    .mem_req_addr   (mem_req_addr),
    .mem_rsp_valid  (mem_rsp_valid),
    .mem_rsp_data   (mem_rsp_data),
    .hit_count      (hit_count),
    .miss_count     (miss_count),
    .read_count     (read_count)
  );
endmodule

// File: tb/tb_xlate_unit.sv
module tb_xlate_unit;
  localparam logic [31:0] PDB = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, rsp_fault, mem_req_valid;
  logic [31:0] rsp_paddr, mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [31:0] hit_count, miss_count, read_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xlate_unit dut (
    .clk(clk), .rst(rst), .flush(flush), .pd_base(PDB),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .hit_count(hit_count), .miss_count(miss_count), .read_count(read_count)
  );

  // page tables: directory entry d points at frame 0x400+d, absent for d=0x3FF;
  // table entry (d,t) maps to frame {d^0x155, t}, absent for d=7,t=3
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [9:0] d, t;
    if (a[31:12] == PDB[31:12]) begin
      d = a[11:2];
      return {20'h00400 + {10'd0, d}, 11'd0, (d != 10'h3FF)};
    end else if (a[31:22] == 10'h001) begin
      d = a[21:12];
      t = a[11:2];
      return {d ^ 10'h155, t, 11'd0, !(d == 10'd7 && t == 10'd3)};
    end
    return 32'h0;
  endfunction

  function automatic logic [31:0] exp_pa(input logic [31:0] va);
    return {va[31:22] ^ 10'h155, va[21:12], va[11:0]};
  endfunction

  logic        m_v = 1'b0;
  logic [31:0] m_a = '0;
  always @(posedge clk) begin
    m_v           <= mem_req_valid;
    m_a           <= mem_req_addr;
    mem_rsp_valid <= m_v;
    mem_rsp_data  <= mem_word(m_a);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xlate(input logic [31:0] va, output logic [31:0] pa, output logic flt,
                       output int rd, output int hits);
    int r0, h0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    r0 = int'(read_count);
    h0 = int'(hit_count);
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    pa   = rsp_paddr;
    flt  = rsp_fault;
    rd   = int'(read_count) - r0;
    hits = int'(hit_count) - h0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  localparam int NV = 13;
  localparam logic [31:0] V_VA [NV] = '{
    32'h0000_0ABC, 32'h0000_0FFC, 32'h0000_1004, 32'h0000_2008, 32'h0000_0010,
    32'h0040_0000, 32'h0080_0000, 32'h0000_3000, 32'h01C0_3000, 32'h01C0_3004,
    32'hFFC0_0000, 32'hFFC0_0004, 32'h01C0_5000 };
  localparam logic V_FLT [NV] = '{0,0,0,0,0, 0,0,0,1,1, 1,1,0};
  localparam int   V_RD  [NV] = '{2,0,1,1,1, 2,2,2,2,1, 1,1,1};
  localparam string V_REQ [NV] = '{
    "R5", "R4", "R6", "R3", "R3", "R5", "R6", "R6", "R7", "R7", "R7", "R7", "R7" };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa;
    logic flt;
    int rd, hits, bad, h0, m0, r0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset hit_count", hit_count, 0);
    chk("R10 reset miss_count", miss_count, 0);
    chk("R10 reset read_count", read_count, 0);
    chk("R9 reset req_ready", {31'd0, req_ready}, 1);
    chk("R9 reset rsp_valid", {31'd0, rsp_valid}, 0);

    for (int i = 0; i < NV; i++) begin
      xlate(V_VA[i], pa, flt, rd, hits);
      chk({V_REQ[i], " fault"}, {31'd0, flt}, {31'd0, V_FLT[i]});
      chk({V_REQ[i], " reads"}, rd, V_RD[i]);
      chk("R10 hit delta", hits, (V_RD[i] == 0) ? 1 : 0);
      chk("R1 offset", {20'd0, pa[11:0]}, {20'd0, V_VA[i][11:0]});
      if (!V_FLT[i]) chk("R1 paddr", pa, exp_pa(V_VA[i]));
    end

    // R8 flush then a previously cached page walks both levels
    do_flush();
    xlate(32'h01C0_5000, pa, flt, rd, hits);
    chk("R8 flush reads", rd, 2);

    // R2/R9 walk addresses and busy handshake
    do_flush();
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = 32'h0140_2ABC;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 ready low in walk", {31'd0, req_ready}, 0);
    chk("R2 dir read addr", mem_req_addr, PDB + 32'h14);
    while (!mem_req_valid || mem_req_addr == PDB + 32'h14) @(negedge clk);
    chk("R2 table read addr", mem_req_addr, 32'h0040_5008);
    chk("R9 ready low second read", {31'd0, req_ready}, 0);
    while (!rsp_valid) @(negedge clk);
    chk("R1 walk paddr", rsp_paddr, exp_pa(32'h0140_2ABC));

    // R8 reset clears caches and counters
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    xlate(32'h0140_2ABC, pa, flt, rd, hits);
    chk("R8 reset reads", rd, 2);
    chk("R10 counters after reset", miss_count, 1);

    // R11 dense stream over 8 pages, every word
    do_flush();
    h0 = int'(hit_count); m0 = int'(miss_count); r0 = int'(read_count); bad = 0;
    for (int w = 0; w < 8 * 1024; w++) begin
      xlate(32'(w * 4), pa, flt, rd, hits);
      if (flt || pa !== exp_pa(32'(w * 4))) bad++;
    end
    chk("R11 dense bad paddr", bad, 0);
    chk("R11 dense misses", int'(miss_count) - m0, 8);
    chk("R11 dense hits", int'(hit_count) - h0, 8184);
    chk("R6 dense reads", int'(read_count) - r0, 9);

    // R11 8 MB stream: misses per page, sampled at three words per page
    do_flush();
    h0 = int'(hit_count); m0 = int'(miss_count); r0 = int'(read_count); bad = 0;
    for (int p = 0; p < 2048; p++) begin
      for (int k = 0; k < 3; k++) begin
        logic [31:0] va;
        va = {p[19:0], 12'h000} + ((k == 0) ? 32'h0 : (k == 1) ? 32'h800 : 32'hFFC);
        xlate(va, pa, flt, rd, hits);
        if (flt || pa !== exp_pa(va)) bad++;
      end
    end
    chk("R11 8MB bad paddr", bad, 0);
    chk("R11 8MB misses", int'(miss_count) - m0, 2048);
    chk("R11 8MB hits", int'(hit_count) - h0, 4096);
    chk("R6 8MB reads", int'(read_count) - r0, 2050);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule